// File: doc/BRIEF.md
# Minifloat to fixed-point converter

This block turns one byte holding a small sign/exponent/mantissa float into an exact unsigned fixed-point magnitude and a separate sign bit. It also raises one of four class flags: zero, denormal, infinity or NaN. The magnitude has 4 integer bits and 6 fraction bits. Every finite value the byte format can hold, from 2^-6 up to 15.5, fits that grid exactly, so no rounding is ever needed.

A producer presents a byte together with a valid strobe. One clock later the converted result appears, marked by an output valid. The result registers load only on cycles with a valid input, and they hold their value in between. Reset is asserted asynchronously and active low. Inside the block, its release is synchronised to the clock.

Top module: `mf_to_fixed`

## Requirements
- R1: Input bit 7 is the sign, bits 6:4 the exponent field E and bits 3:0 the mantissa field M. For E from 1 to 6 the magnitude equals 1.M × 2^(E-3). On the output, out_mag counts units of 2^-6, so it equals (16+M) << (E-1). In this case all four flags are low.
- R2: E=0 with M≠0 is a denormal worth 0.M × 2^-2. out_mag equals M and out_denorm is high.
- R3: E=0 with M=0 is zero. out_zero is high and out_mag is 0. A set sign bit (negative zero) still gives out_sign=1.
- R4: E=7 with M=0 is infinity. out_inf is high and out_mag is forced to 0.
- R5: E=7 with M≠0 is NaN. out_nan is high and out_mag is forced to 0.
- R6: At most one of out_zero, out_denorm, out_inf and out_nan is high at any time.
- R7: out_valid is high exactly in the cycle that follows a cycle with in_valid high.
- R8: When in_valid is low, out_sign, out_mag and the flags keep their previous values, whatever in_byte carries.
- R9: While rst_n is low, every output is 0.
- R10: out_sign always equals bit 7 of the accepted byte, for every class of input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input byte strobe |
| in_byte | input | 8 | Minifloat code |
| out_valid | output | 1 | Result strobe, one cycle after in_valid |
| out_sign | output | 1 | Sign of the accepted value |
| out_mag | output | 10 | Magnitude, 4 integer and 6 fraction bits |
| out_zero | output | 1 | Value is zero of either sign |
| out_denorm | output | 1 | Value is denormal |
| out_inf | output | 1 | Value is infinity |
| out_nan | output | 1 | Value is NaN |

## Verification
Every result, including out_valid, is due at the first rising edge after the edge that sees in_valid high. The bench drives in_valid for a single cycle on a falling edge and reads all outputs on the next falling edge, half a period after that rising edge. For the hold check, the bench drives a new byte with in_valid low for two cycles and then reads the outputs again. A sweep over all 256 codes compares against a model written from the requirements.

// File: rtl/mf_pkg.sv
package mf_pkg;
  typedef enum logic [2:0] {
    CLS_ZERO,
    CLS_DENORM,
    CLS_NORMAL,
    CLS_INF,
    CLS_NAN
  } mf_class_e;

  typedef struct packed {
    logic zero;
    logic denorm;
    logic inf;
    logic nan;
  } mf_flags_t;
endpackage

// File: rtl/mf_rst_sync.sv
module mf_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_sync_n = stage_q[1];
endmodule

// File: rtl/mf_classify.sv
module mf_classify
  import mf_pkg::*;
#(
  parameter int EXP_W = 3,
  parameter int MAN_W = 4
) (
  input  logic [EXP_W-1:0] exp_f,
  input  logic [MAN_W-1:0] man_f,
  output mf_class_e        cls
);
  localparam logic [EXP_W-1:0] EXP_MAX = {EXP_W{1'b1}};

  always_comb begin
    if (exp_f == '0)          cls = (man_f == '0) ? CLS_ZERO : CLS_DENORM;
    else if (exp_f == EXP_MAX) cls = (man_f == '0) ? CLS_INF : CLS_NAN;
    else                       cls = CLS_NORMAL;
  end
endmodule

// File: rtl/mf_mag_shift.sv
module mf_mag_shift
  import mf_pkg::*;
#(
  parameter int EXP_W = 3,
  parameter int MAN_W = 4,
  parameter int BIAS  = 3,
  parameter int MAG_W = 10,
  parameter int FRAC_W = 6
) (
  input  logic [EXP_W-1:0] exp_f,
  input  logic [MAN_W-1:0] man_f,
  input  mf_class_e        cls,
  output logic [MAG_W-1:0] mag
);
  // Left shift of a denormal mantissa onto the output grid.
  localparam int DEN_SH = FRAC_W - MAN_W - BIAS + 1;
  localparam int PAD_W  = MAG_W - MAN_W - 1;

  logic [MAG_W-1:0] sig_norm;
  logic [MAG_W-1:0] sig_den;
  int               norm_sh;

  assign sig_norm = {{PAD_W{1'b0}}, 1'b1, man_f};
  assign sig_den  = {{(PAD_W+1){1'b0}}, man_f};

  always_comb begin
    norm_sh = int'(exp_f) - 1 + DEN_SH;
    unique case (cls)
      CLS_NORMAL: mag = sig_norm << norm_sh;
      CLS_DENORM: mag = sig_den << DEN_SH;
      default:    mag = '0;
    endcase
  end
endmodule

// File: rtl/mf_to_fixed.sv
module mf_to_fixed
  import mf_pkg::*;
#(
  parameter int EXP_W  = 3,
  parameter int MAN_W  = 4,
  parameter int BIAS   = 3,
  parameter int INT_W  = 4,
  parameter int FRAC_W = 6
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   in_valid,
  input  logic [EXP_W+MAN_W:0]   in_byte,
  output logic                   out_valid,
  output logic                   out_sign,
  output logic [INT_W+FRAC_W-1:0] out_mag,
  output logic                   out_zero,
  output logic                   out_denorm,
  output logic                   out_inf,
  output logic                   out_nan
);
  localparam int MAG_W  = INT_W + FRAC_W;
  localparam int SIGN_B = EXP_W + MAN_W;

  logic             rst_sync_n;
  logic [EXP_W-1:0] exp_f;
  logic [MAN_W-1:0] man_f;
  mf_class_e        cls;
  logic [MAG_W-1:0] mag_d, mag_q;
  mf_flags_t        flags_d, flags_q;
  logic             sign_d, sign_q, valid_q;
  logic             load_en;

  assign exp_f   = in_byte[SIGN_B-1:MAN_W];
  assign man_f   = in_byte[MAN_W-1:0];
  assign load_en = in_valid;

  mf_rst_sync u_rst_sync (.clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n));

  mf_classify #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_classify (
    .exp_f(exp_f), .man_f(man_f), .cls(cls));

  mf_mag_shift #(.EXP_W(EXP_W), .MAN_W(MAN_W), .BIAS(BIAS),
                 .MAG_W(MAG_W), .FRAC_W(FRAC_W)) u_mag_shift (
    .exp_f(exp_f), .man_f(man_f), .cls(cls), .mag(mag_d));

  // Next-state process
  always_comb begin
    sign_d         = in_byte[SIGN_B];
    flags_d        = '0;
    flags_d.zero   = (cls == CLS_ZERO);
    flags_d.denorm = (cls == CLS_DENORM);
    flags_d.inf    = (cls == CLS_INF);
    flags_d.nan    = (cls == CLS_NAN);
  end

  // Register process
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      valid_q <= 1'b0;
      sign_q  <= 1'b0;
      mag_q   <= '0;
      flags_q <= '0;
    end else begin
      valid_q <= in_valid;
      if (load_en) begin
        sign_q  <= sign_d;
        mag_q   <= mag_d;
        flags_q <= flags_d;
      end
    end
  end

  assign out_valid  = valid_q;
  assign out_sign   = sign_q;
  assign out_mag    = mag_q;
  assign out_zero   = flags_q.zero;
  assign out_denorm = flags_q.denorm;
  assign out_inf    = flags_q.inf;
  assign out_nan    = flags_q.nan;
endmodule

// File: rtl/mf_to_fixed_chk.sv
module mf_to_fixed_chk #(
  parameter int MAG_W = 10
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic [7:0]       in_byte,
  input logic             out_valid,
  input logic             out_sign,
  input logic [MAG_W-1:0] out_mag,
  input logic             out_zero,
  input logic             out_denorm,
  input logic             out_inf,
  input logic             out_nan
);
  AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({out_zero, out_denorm, out_inf, out_nan})); // R6
  AST_VALID_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid); // R7
  AST_VALID_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid); // R7
  AST_HOLD_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(out_mag) && $stable(out_sign) && $stable(out_zero))); // R8
  AST_SIGN_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> (out_sign == $past(in_byte[7]))); // R10
  AST_INF_MAG: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_byte[6:0] == 7'h70) |=> (out_inf && out_mag == '0)); // R4
  AST_NAN_MAG: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_byte[6:4] == 3'b111 && in_byte[3:0] != 4'h0) |=> (out_nan && out_mag == '0)); // R5
  AST_ZERO_MAG: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_byte[6:0] == 7'h00) |=> (out_zero && out_mag == '0)); // R3
  AST_DENORM_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    out_denorm |-> (out_mag != '0 && out_mag < 16)); // R2
endmodule

bind mf_to_fixed mf_to_fixed_chk #(.MAG_W(MAG_W)) i_chk (
  .clk(clk), .rst_n(rst_sync_n), .in_valid(in_valid), .in_byte(in_byte),
  .out_valid(out_valid), .out_sign(out_sign), .out_mag(out_mag),
  .out_zero(out_zero), .out_denorm(out_denorm), .out_inf(out_inf),
  .out_nan(out_nan));

// File: tb/test_mf_to_fixed.sv
module test_mf_to_fixed;
  logic       clk;
  logic       rst_n;
  logic       in_valid;
  logic [7:0] in_byte;
  logic       out_valid, out_sign, out_zero, out_denorm, out_inf, out_nan;
  logic [9:0] out_mag;
  int n_checks;
  int n_fails;
  bit done;

  mf_to_fixed i_mf_to_fixed (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_byte(in_byte),
    .out_valid(out_valid), .out_sign(out_sign), .out_mag(out_mag),
    .out_zero(out_zero), .out_denorm(out_denorm), .out_inf(out_inf),
    .out_nan(out_nan));

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  // Expected magnitude, in units of 2^-6, from R1, R2, R4 and R5
  function automatic logic [9:0] exp_mag(input logic [7:0] b);
    int e, m;
    e = int'(b[6:4]);
    m = int'(b[3:0]);
    if (e == 0)      return 10'(m);
    else if (e == 7) return 10'd0;
    else             return 10'((16 + m) << (e - 1));
  endfunction

  // Expected flags {zero, denorm, inf, nan}, from R2 to R5
  function automatic logic [3:0] exp_flags(input logic [7:0] b);
    if (b[6:4] == 3'd0) return (b[3:0] == 4'd0) ? 4'b1000 : 4'b0100;
    if (b[6:4] == 3'd7) return (b[3:0] == 4'd0) ? 4'b0010 : 4'b0001;
    return 4'b0000;
  endfunction

  task automatic check(input string req, input logic v, input logic s,
                       input logic [9:0] m, input logic [3:0] f);
    logic [3:0] af;
    af = {out_zero, out_denorm, out_inf, out_nan};
    n_checks++;
    if (out_valid !== v || out_sign !== s || out_mag !== m || af !== f) begin
      n_fails++;
      $display("FAIL %s: actual v=%b s=%b mag=%0d flags=%b expected v=%b s=%b mag=%0d flags=%b",
               req, out_valid, out_sign, out_mag, af, v, s, m, f);
    end
  endtask

  // Present one byte for one cycle; outputs read one edge later.
  task automatic apply(input logic [7:0] b, input string req);
    @(negedge clk);
    in_valid = 1'b1;
    in_byte  = b;
    @(negedge clk);
    in_valid = 1'b0;
    check(req, 1'b1, b[7], exp_mag(b), exp_flags(b));
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    in_valid = 1'b0;
    in_byte = 8'h00;
    repeat (3) @(negedge clk);
    check("R9 reset", 1'b0, 1'b0, 10'd0, 4'b0000);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R9 after release", 1'b0, 1'b0, 10'd0, 4'b0000);
  endtask

  task automatic t_normals;
    apply(8'h30, "R1 one");
    check("R1 one = 64", 1'b1, 1'b0, 10'd64, 4'b0000);
    apply(8'h6F, "R1 max 15.5");
    check("R1 max = 992", 1'b1, 1'b0, 10'd992, 4'b0000);
    apply(8'h10, "R1 min normal 0.25");
    check("R1 min = 16", 1'b1, 1'b0, 10'd16, 4'b0000);
    apply(8'h69, "R1 12.5");
    check("R1 12.5 = 800", 1'b1, 1'b0, 10'd800, 4'b0000);
    apply(8'hB0, "R10 negative one");
  endtask

  task automatic t_denormals;
    apply(8'h01, "R2 smallest");
    check("R2 smallest = 1", 1'b1, 1'b0, 10'd1, 4'b0100);
    apply(8'h0F, "R2 largest");
    apply(8'h88, "R2 negative denormal");
  endtask

  task automatic t_zero;
    apply(8'h00, "R3 positive zero");
    apply(8'h80, "R3 negative zero");
    check("R3 negative zero sign", 1'b1, 1'b1, 10'd0, 4'b1000);
  endtask

  task automatic t_special;
    apply(8'h70, "R4 +inf");
    check("R4 +inf", 1'b1, 1'b0, 10'd0, 4'b0010);
    apply(8'hF0, "R4 -inf");
    apply(8'h71, "R5 nan");
    apply(8'hFF, "R5 negative nan");
    check("R5 negative nan sign", 1'b1, 1'b1, 10'd0, 4'b0001);
  endtask

  task automatic t_hold;
    apply(8'h30, "R8 load");
    @(negedge clk);
    in_byte = 8'hD5;
    check("R7 valid drops", 1'b0, 1'b0, 10'd64, 4'b0000);
    @(negedge clk);
    check("R8 hold", 1'b0, 1'b0, 10'd64, 4'b0000);
  endtask

  task automatic t_sweep;
    for (int i = 0; i < 256; i++) apply(8'(i), "R6 sweep");
  endtask

  task automatic t_mid_reset;
    apply(8'h6F, "R9 preload");
    rst_n = 1'b0;
    #1;
    check("R9 mid-run reset", 1'b0, 1'b0, 10'd0, 4'b0000);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    n_checks = 0;
    n_fails = 0;
    done = 1'b0;
    t_reset();
    t_normals();
    t_denormals();
    t_zero();
    t_special();
    t_hold();
    t_sweep();
    t_mid_reset();
    apply(8'h42, "R1 after reset");
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end
endmodule